// File: doc/BRIEF.md
# Modem Handshake Status Register

This block watches the four inbound handshake lines of a serial port: carrier detect, ring indicator, data set ready and clear to send. All four are active low at the pins. The block reports the asserted state of each line in the upper half of an 8-bit status byte. In the lower half it keeps a sticky change flag for each line. A read strobe clears those flags, and a modem interrupt request stays high while any flag is set.

A small control register drives the four outbound handshake pins: data terminal ready, request to send and two general outputs. A loopback bit turns the port back on itself. In loopback the outbound pins park in their inactive state. The control bits then feed the inbound status logic in place of the external lines, so software can exercise change detection and the interrupt without a cable.

External inputs are asynchronous and pass through a two-stage synchronizer first. A level change on a pin shows up in the status byte on the third rising clock edge after it is applied.

Top module: `modem_status_unit`

## Requirements
- R1: Status bits 7, 6, 5 and 4 show the inverted level of carrier detect, ring indicator, data set ready and clear to send respectively. A pin change is visible on the third rising edge after it is applied.
- R2: Status bit 3 (carrier detect), bit 1 (data set ready) and bit 0 (clear to send) are set by any level change of that line. Each stays set until a read.
- R3: Status bit 2 is set only when the ring indicator pin goes from low to high. A high-to-low change of that pin leaves bit 2 unchanged.
- R4: A cycle with the status read strobe high clears bits 3..0 from the next cycle on. The upper bits are not affected.
- R5: The interrupt request output is high exactly while any of status bits 3..0 is 1.
- R6: Control bits 0, 1, 2 and 3 drive data terminal ready, request to send, general output 1 and general output 2. A 1 drives the pin low and a 0 drives it high, from the cycle after the write.
- R7: With control bit 4 set, all four outbound pins are high and the external inbound pins are ignored. The inbound lines are taken from the control bits: request to send feeds clear to send, data terminal ready feeds data set ready, output 1 feeds ring indicator, and output 2 feeds carrier detect. The status levels, change flags and interrupt then follow these internal lines one cycle after the control write.
- R8: Control read-back returns bits 4..0 as written. Bits 7..5 always read 0, even when written as 1.
- R9: A change detected in the same cycle as a status read leaves its flag set after the read.
- R10: After reset, with all inbound pins high, the status byte, the control read-back and the interrupt are 0, and all outbound pins are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ctrlWrEn | input | 1 | Write strobe for the control register |
| ctrlWrData | input | 8 | Control write data |
| ctrlRdData | output | 8 | Control register read-back |
| statRdEn | input | 1 | Status read strobe; clears the change flags |
| statusData | output | 8 | Status byte: line levels high, change flags low |
| dcdInN | input | 1 | Carrier detect pin, active low, asynchronous |
| riInN | input | 1 | Ring indicator pin, active low, asynchronous |
| dsrInN | input | 1 | Data set ready pin, active low, asynchronous |
| ctsInN | input | 1 | Clear to send pin, active low, asynchronous |
| dtrOutN | output | 1 | Data terminal ready pin, active low |
| rtsOutN | output | 1 | Request to send pin, active low |
| out1OutN | output | 1 | General output 1, active low |
| out2OutN | output | 1 | General output 2, active low |
| modemIrq | output | 1 | Modem status interrupt request |

## Verification
The inbound pins are treated as asynchronous. For that reason the assertions reason only about the synchronized and loopback-selected line values, never about the raw pins. They also take for granted that the read strobe is a single-cycle pulse. The stimulus changes pins and strobes only at the falling clock edge, and holds every pin level for at least three cycles so that each transition passes through the synchronizer. Read pulses last exactly one cycle. Collision cases are timed so that a synchronized change lands on the same rising edge as the read.

// File: rtl/msr_pkg.sv
package msr_pkg;
  localparam int LINE_COUNT = 4;
  // bit position of each inbound line inside a status nibble
  localparam int IDX_CTS = 0;
  localparam int IDX_DSR = 1;
  localparam int IDX_RI  = 2;
  localparam int IDX_DCD = 3;
  // bit position of each outbound line inside the control register
  localparam int CB_DTR  = 0;
  localparam int CB_RTS  = 1;
  localparam int CB_OUT1 = 2;
  localparam int CB_OUT2 = 3;
  localparam int CB_LOOP = 4;
  localparam int CTRL_BITS = 5;

  typedef struct packed {
    logic                  loopEn;
    logic                  clrFlags;
    logic [LINE_COUNT-1:0] loopLinesN;
  } msrStrobe_t;
endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH = 4,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= {STAGES{RESET_VAL}};
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) begin
        chain[s] <= chain[s-1];
      end
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/msr_ctrl.sv
module msr_ctrl
  import msr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ctrlWrEn,
  input  logic [CTRL_BITS-1:0]  ctrlWrBits,
  input  logic                  statRdEn,
  output logic [7:0]            ctrlRdData,
  output logic [LINE_COUNT-1:0] pinsN,
  output msrStrobe_t            strobe
);
  localparam int PAD_BITS = 8 - CTRL_BITS;

  logic [CTRL_BITS-1:0] ctrlReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (ctrlWrEn) begin
      ctrlReg <= ctrlWrBits;
    end
  end

  assign ctrlRdData = {{PAD_BITS{1'b0}}, ctrlReg};

  always_comb begin
    strobe = '0;
    strobe.loopEn   = ctrlReg[CB_LOOP];
    strobe.clrFlags = statRdEn;
    strobe.loopLinesN[IDX_CTS] = ~ctrlReg[CB_RTS];
    strobe.loopLinesN[IDX_DSR] = ~ctrlReg[CB_DTR];
    strobe.loopLinesN[IDX_RI]  = ~ctrlReg[CB_OUT1];
    strobe.loopLinesN[IDX_DCD] = ~ctrlReg[CB_OUT2];
  end

  assign pinsN = ctrlReg[CB_LOOP] ? '1 : ~ctrlReg[LINE_COUNT-1:0];

  // R6: pins follow a non-loopback write one cycle later
  a_r6_pins_follow_write: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && !ctrlWrBits[CB_LOOP]) |=> (pinsN == ~$past(ctrlWrBits[LINE_COUNT-1:0])));

  // R7: loopback parks every outbound pin high
  a_r7_pins_idle_in_loop: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && ctrlWrBits[CB_LOOP]) |=> (pinsN == '1));
endmodule

// File: rtl/msr_datapath.sv
module msr_datapath
  import msr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LINE_COUNT-1:0] extLinesN,
  input  msrStrobe_t            strobe,
  output logic [7:0]            statusData,
  output logic                  irq
);
  logic [LINE_COUNT-1:0] syncN;
  logic [LINE_COUNT-1:0] selN;
  logic [LINE_COUNT-1:0] prevN;
  logic [LINE_COUNT-1:0] chg;
  logic [LINE_COUNT-1:0] flags;

  msr_sync #(
    .STAGES(SYNC_STAGES),
    .WIDTH(LINE_COUNT),
    .RESET_VAL('1)
  ) sync_i (
    .clk (clk),
    .rstN(rstN),
    .din (extLinesN),
    .dout(syncN)
  );

  assign selN = strobe.loopEn ? strobe.loopLinesN : syncN;

  for (genvar i = 0; i < LINE_COUNT; i++) begin : g_edge
    if (i == IDX_RI) begin : g_rise_only
      // pin low to high: previous 0, now 1
      assign chg[i] = selN[i] & ~prevN[i];
    end else begin : g_any
      assign chg[i] = selN[i] ^ prevN[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevN <= '1;
      flags <= '0;
    end else begin
      prevN <= selN;
      flags <= (strobe.clrFlags ? '0 : flags) | chg;
    end
  end

  assign statusData = {~prevN, flags};
  assign irq = |flags;

  // R2: flags only clear through a read
  a_r2_flags_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clrFlags |=> ((flags & $past(flags)) == $past(flags)));

  // R3: a falling ring-indicator pin never sets its flag
  a_r3_ri_fall_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!flags[IDX_RI] && prevN[IDX_RI] && !selN[IDX_RI]) |=> !flags[IDX_RI]);

  // R4: a read with no concurrent change empties the flags
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrFlags && chg == '0) |=> (flags == '0));

  // R9: a change coinciding with a read survives it
  a_r9_change_beats_read: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrFlags |=> (flags == $past(chg)));
endmodule

// File: rtl/modem_status_unit.sv
module modem_status_unit
  import msr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWrEn,
  input  logic [7:0] ctrlWrData,
  output logic [7:0] ctrlRdData,
  input  logic       statRdEn,
  output logic [7:0] statusData,
  input  logic       dcdInN,
  input  logic       riInN,
  input  logic       dsrInN,
  input  logic       ctsInN,
  output logic       dtrOutN,
  output logic       rtsOutN,
  output logic       out1OutN,
  output logic       out2OutN,
  output logic       modemIrq
);
  msrStrobe_t            strobe;
  logic [LINE_COUNT-1:0] pinsN;
  logic [LINE_COUNT-1:0] extLinesN;

  always_comb begin
    extLinesN = '0;
    extLinesN[IDX_CTS] = ctsInN;
    extLinesN[IDX_DSR] = dsrInN;
    extLinesN[IDX_RI]  = riInN;
    extLinesN[IDX_DCD] = dcdInN;
  end

  msr_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctrlWrEn  (ctrlWrEn),
    .ctrlWrBits(ctrlWrData[CTRL_BITS-1:0]),
    .statRdEn  (statRdEn),
    .ctrlRdData(ctrlRdData),
    .pinsN     (pinsN),
    .strobe    (strobe)
  );

  msr_datapath #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .extLinesN (extLinesN),
    .strobe    (strobe),
    .statusData(statusData),
    .irq       (modemIrq)
  );

  assign dtrOutN  = pinsN[CB_DTR];
  assign rtsOutN  = pinsN[CB_RTS];
  assign out1OutN = pinsN[CB_OUT1];
  assign out2OutN = pinsN[CB_OUT2];

  // R5: any pending flag raises the request
  a_r5_irq_on_flag: assert property (@(posedge clk) disable iff (!rstN)
    (|statusData[3:0]) |-> modemIrq);

  // R8: upper control bits never stick
  a_r8_upper_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && |ctrlWrData[7:5]) |=> (ctrlRdData[7:5] == 3'b000));
endmodule

// File: tb/modem_status_unit_tb_top.sv
`timescale 1ns/1ps
module modem_status_unit_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctrlWrEn = 1'b0;
  logic [7:0] ctrlWrData = 8'h00;
  logic [7:0] ctrlRdData;
  logic       statRdEn = 1'b0;
  logic [7:0] statusData;
  logic       dcdInN = 1'b1;
  logic       riInN = 1'b1;
  logic       dsrInN = 1'b1;
  logic       ctsInN = 1'b1;
  logic       dtrOutN, rtsOutN, out1OutN, out2OutN, modemIrq;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  modem_status_unit dut_i (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .ctrlRdData(ctrlRdData), .statRdEn(statRdEn), .statusData(statusData),
    .dcdInN(dcdInN), .riInN(riInN), .dsrInN(dsrInN), .ctsInN(ctsInN),
    .dtrOutN(dtrOutN), .rtsOutN(rtsOutN), .out1OutN(out1OutN), .out2OutN(out2OutN),
    .modemIrq(modemIrq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic readStatus(output logic [7:0] val);
    statRdEn = 1'b1;
    val = statusData;
    tick();
    statRdEn = 1'b0;
  endtask

  task automatic writeCtrl(input logic [7:0] val);
    ctrlWrEn = 1'b1;
    ctrlWrData = val;
    tick();
    ctrlWrEn = 1'b0;
    ctrlWrData = 8'h00;
  endtask

  function automatic logic [7:0] pinsVec();
    return {4'h0, out2OutN, out1OutN, rtsOutN, dtrOutN};
  endfunction

  task automatic t_reset();
    rstN = 1'b0;
    tick(3);
    rstN = 1'b1;
    tick();
    check("R10 status", statusData, 8'h00);
    check("R10 ctrl", ctrlRdData, 8'h00);
    check("R10 pins", pinsVec(), 8'h0F);
    check("R10 irq", {7'd0, modemIrq}, 8'h00);
  endtask

  task automatic t_ext_levels();
    logic [7:0] rd;
    ctsInN = 1'b0;
    tick(2);
    check("R1 latency not yet", statusData, 8'h00);
    tick();
    check("R1 R2 cts", statusData, 8'h11);
    check("R5 irq set", {7'd0, modemIrq}, 8'h01);
    dcdInN = 1'b0;
    tick(3);
    check("R1 R2 dcd", statusData, 8'h99);
    readStatus(rd);
    check("R4 read value", rd, 8'h99);
    check("R4 cleared", statusData, 8'h90);
    check("R5 irq clear", {7'd0, modemIrq}, 8'h00);
    ctsInN = 1'b1;
    dcdInN = 1'b1;
    tick(3);
    check("R2 release", statusData, 8'h09);
    readStatus(rd);
    dsrInN = 1'b0;
    tick(3);
    check("R2 dsr", statusData, 8'h22);
    dsrInN = 1'b1;
    tick(3);
    check("R2 dsr back", statusData, 8'h02);
    readStatus(rd);
    check("R4 empty", statusData, 8'h00);
  endtask

  task automatic t_ri_edge();
    logic [7:0] rd;
    riInN = 1'b0;
    tick(3);
    check("R3 fall no flag", statusData, 8'h40);
    check("R3 fall no irq", {7'd0, modemIrq}, 8'h00);
    riInN = 1'b1;
    tick(3);
    check("R3 rise flag", statusData, 8'h04);
    readStatus(rd);
    check("R3 cleared", statusData, 8'h00);
  endtask

  task automatic t_collision();
    logic [7:0] rd;
    dsrInN = 1'b0;
    tick(3);
    ctsInN = 1'b0;
    tick(2);
    readStatus(rd);
    check("R9 read value", rd, 8'h22);
    check("R9 change kept", statusData, 8'h31);
    dsrInN = 1'b1;
    ctsInN = 1'b1;
    tick(3);
    readStatus(rd);
    check("R9 cleanup", statusData, 8'h00);
  endtask

  task automatic t_ctrl_pins();
    writeCtrl(8'hEB);
    check("R8 readback", ctrlRdData, 8'h0B);
    check("R6 pins eb", pinsVec(), 8'h04);
    tick(3);
    check("R6 status untouched", statusData, 8'h00);
    writeCtrl(8'h04);
    check("R6 pins out1", pinsVec(), 8'h0B);
    writeCtrl(8'h00);
    check("R6 pins idle", pinsVec(), 8'h0F);
  endtask

  task automatic t_loopback();
    logic [7:0] rd;
    {dcdInN, riInN, dsrInN, ctsInN} = 4'h0;
    tick(3);
    readStatus(rd);
    check("R7 ext all active", statusData, 8'hF0);
    writeCtrl(8'h10);
    check("R7 pins loop", pinsVec(), 8'h0F);
    tick();
    check("R7 loop entry", statusData, 8'h0F);
    readStatus(rd);
    writeCtrl(8'h12);
    check("R7 pins rts loop", pinsVec(), 8'h0F);
    tick();
    check("R7 rts to cts", statusData, 8'h11);
    readStatus(rd);
    writeCtrl(8'h11);
    tick();
    check("R7 dtr to dsr", statusData, 8'h23);
    readStatus(rd);
    writeCtrl(8'h14);
    tick();
    check("R7 R3 out1 to ri fall", statusData, 8'h42);
    readStatus(rd);
    writeCtrl(8'h18);
    tick();
    check("R7 R3 out2 to dcd ri rise", statusData, 8'h8C);
    check("R7 R5 irq loop", {7'd0, modemIrq}, 8'h01);
    readStatus(rd);
    {dcdInN, riInN, dsrInN, ctsInN} = 4'hF;
    tick(4);
    check("R7 ext ignored", statusData, 8'h80);
    check("R7 pins still idle", pinsVec(), 8'h0F);
    writeCtrl(8'h00);
    tick();
    check("R7 loop exit", statusData, 8'h08);
    readStatus(rd);
    check("R7 final", statusData, 8'h00);
  endtask

  initial begin
    tick();
    t_reset();
    t_ext_levels();
    t_ri_edge();
    t_collision();
    t_ctrl_pins();
    t_loopback();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule